// File: doc/BRIEF.md
# Release-Point Bus Arbiter

This block decides which of three bus masters owns a single shared external bus: a CPU, a transfer controller and a DMA controller. Priority is fixed, with the DMA controller first, the transfer controller second and the CPU last. The CPU is the owner by default. A pending request from a higher-priority master never takes the bus away at once. Ownership moves only when the current owner reports that it has reached a safe release point, and what counts as a release point depends on which master holds the bus and what it is doing.

The arbiter is a small synchronous state holder. Each cycle it reads the request lines and the status of the current owner. It then decides whether this cycle is a release point and, if so, which requester wins. Any change of owner shows up on the one-hot grant outputs after the next rising clock edge. The refresh request is accepted as an input but plays no part in arbitration, because refresh runs alongside external accesses.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is active, and on the first cycle after it ends, the grant vector `gnt` equals 3'b001. Bit 0 is the CPU, bit 1 is the transfer controller and bit 2 is the DMA controller.
- R2: Exactly one bit of `gnt` is set in every cycle.
- R3: While the CPU owns the bus and is not asleep, it hands the bus over only in a cycle where `cpuCycleEnd` is high and `cpuSplitBusy` is low. While `cpuSplitBusy` is high, the CPU keeps the bus.
- R4: While the CPU owns the bus and `cpuSleep` is high, a pending request wins on the next edge, whatever the values of `cpuCycleEnd` and `cpuSplitBusy`.
- R5: While the transfer controller owns the bus, a release point is any cycle where `xferPhase` is zero (idle) or odd (a phase has just ended: 1 vector read, 3 register-info read, 5 data transfer, 7 register-info write). The even non-zero codes 2, 4 and 6 mark the inside of a multi-state phase, and the grant holds during them.
- R6: While the DMA controller owns the bus in `dmaMode` 2'b00 (cycle steal) or 2'b01 (single or normal external request), a release point is any cycle where `dmaXferDone` is high.
- R7: While the DMA controller owns the bus in `dmaMode` 2'b10 (block), only `dmaBlockDone` makes a release point. In `dmaMode` 2'b11 (burst), only `dmaBurstDone` does. The other done inputs are ignored in these modes.
- R8: At a release point the new owner is the DMA controller if `dmaReq` is high, otherwise the transfer controller if `xferReq` is high, otherwise the CPU.
- R9: At a release point where the owner is still requesting and no higher-priority request is pending, the owner keeps the grant with no idle cycle in between.
- R10: `refreshReq` has no effect on `gnt`.
- R11: A transfer-controller or DMA owner whose request has dropped still keeps the bus until its own release point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferReq | input | 1 | Bus request from the transfer controller |
| dmaReq | input | 1 | Bus request from the DMA controller |
| cpuCycleEnd | input | 1 | The CPU is at a break between bus cycles |
| cpuSplitBusy | input | 1 | The CPU is inside a split access, such as a longword access |
| cpuSleep | input | 1 | The CPU is in sleep mode |
| xferPhase | input | PHASE_W | Phase code of the transfer controller |
| dmaMode | input | 2 | DMA mode: 00 steal, 01 single, 10 block, 11 burst |
| dmaXferDone | input | 1 | The DMA controller has finished one transfer |
| dmaBlockDone | input | 1 | The DMA controller has finished one block |
| dmaBurstDone | input | 1 | The DMA controller has finished the whole burst |
| refreshReq | input | 1 | Refresh request (does not arbitrate) |
| gnt | output | 3 | One-hot grant: bit 0 CPU, bit 1 transfer controller, bit 2 DMA |

## Verification
The hardest case to reach is an owner that keeps the bus while another master is already waiting. Examples are a DMA controller in block or burst mode whose other done inputs fire, and a transfer controller sitting on an even phase code. Both require the grant to have been moved to that master first, through the right chain of release points. Directed sequences build each chain step by step: CPU to transfer controller, then to the DMA controller in each of its modes, then back. A long stretch of seeded random stimulus with skewed probabilities then mixes mid-phase codes, sleep and done pulses, and checks every cycle against a bench model of the release rules.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int NUM_MASTERS = 3;

  typedef enum logic [1:0] {
    OWN_CPU  = 2'd0,
    OWN_XFER = 2'd1,
    OWN_DMA  = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    DMA_STEAL  = 2'd0,
    DMA_SINGLE = 2'd1,
    DMA_BLOCK  = 2'd2,
    DMA_BURST  = 2'd3
  } dma_mode_e;

  // Strobes from control to the grant datapath
  typedef struct packed {
    logic   load;
    owner_e nextOwner;
  } grant_strobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  owner_e         curOwner,
  input  logic           xferReq,
  input  logic           dmaReq,
  input  logic           cpuCycleEnd,
  input  logic           cpuSplitBusy,
  input  logic           cpuSleep,
  input  logic [PHASE_W-1:0] xferPhase,
  input  logic [1:0]     dmaMode,
  input  logic           dmaXferDone,
  input  logic           dmaBlockDone,
  input  logic           dmaBurstDone,
  output grant_strobe_t  strobe
);

  localparam logic [PHASE_W-1:0] PHASE_IDLE = '0;

  logic   cpuRelease;
  logic   xferRelease;
  logic   dmaRelease;
  logic   releaseNow;
  owner_e winner;

  // CPU: at a cycle break outside a split access, or whenever asleep
  always_comb begin
    cpuRelease = cpuSleep | (cpuCycleEnd & ~cpuSplitBusy);
  end

  // Transfer controller: idle code, or an odd code that closes a phase
  always_comb begin
    xferRelease = (xferPhase == PHASE_IDLE) | xferPhase[0];
  end

  // DMA controller: the done event that matches the active mode
  always_comb begin
    unique case (dma_mode_e'(dmaMode))
      DMA_STEAL,
      DMA_SINGLE: dmaRelease = dmaXferDone;
      DMA_BLOCK:  dmaRelease = dmaBlockDone;
      DMA_BURST:  dmaRelease = dmaBurstDone;
      default:    dmaRelease = 1'b0;
    endcase
  end

  always_comb begin
    unique case (curOwner)
      OWN_CPU:  releaseNow = cpuRelease;
      OWN_XFER: releaseNow = xferRelease;
      OWN_DMA:  releaseNow = dmaRelease;
      default:  releaseNow = 1'b1;
    endcase
  end

  // Fixed priority: DMA, transfer controller, then CPU as default
  always_comb begin
    if (dmaReq)       winner = OWN_DMA;
    else if (xferReq) winner = OWN_XFER;
    else              winner = OWN_CPU;
  end

  always_comb begin
    strobe.nextOwner = winner;
    strobe.load      = releaseNow & (winner != curOwner);
  end

endmodule

// File: rtl/arb_grant_dp.sv
module arb_grant_dp
  import arb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  grant_strobe_t          strobe,
  output owner_e                 curOwner,
  output logic [NUM_MASTERS-1:0] gnt
);

  owner_e ownerQ;

  always_ff @(posedge clk) begin
    if (!rstN)            ownerQ <= OWN_CPU;
    else if (strobe.load) ownerQ <= strobe.nextOwner;
  end

  assign curOwner = ownerQ;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_gnt
    assign gnt[i] = (ownerQ == owner_e'(i));
  end

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferReq,
  input  logic               dmaReq,
  input  logic               cpuCycleEnd,
  input  logic               cpuSplitBusy,
  input  logic               cpuSleep,
  input  logic [PHASE_W-1:0] xferPhase,
  input  logic [1:0]         dmaMode,
  input  logic               dmaXferDone,
  input  logic               dmaBlockDone,
  input  logic               dmaBurstDone,
  input  logic               refreshReq,
  output logic [2:0]         gnt
);

  grant_strobe_t strobe;
  owner_e        curOwner;

  arb_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .curOwner     (curOwner),
    .xferReq      (xferReq),
    .dmaReq       (dmaReq),
    .cpuCycleEnd  (cpuCycleEnd),
    .cpuSplitBusy (cpuSplitBusy),
    .cpuSleep     (cpuSleep),
    .xferPhase    (xferPhase),
    .dmaMode      (dmaMode),
    .dmaXferDone  (dmaXferDone),
    .dmaBlockDone (dmaBlockDone),
    .dmaBurstDone (dmaBurstDone),
    .strobe       (strobe)
  );

  arb_grant_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curOwner (curOwner),
    .gnt      (gnt)
  );

endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               xferReq,
  input logic               dmaReq,
  input logic               cpuSplitBusy,
  input logic               cpuSleep,
  input logic [PHASE_W-1:0] xferPhase,
  input logic [1:0]         dmaMode,
  input logic               dmaBurstDone,
  input logic               refreshReq,
  input logic [2:0]         gnt
);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gnt) == 1);

  // R3
  cpu_split_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    gnt[0] && cpuSplitBusy && !cpuSleep |=> gnt[0]);

  // R4
  cpu_sleep_handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    gnt[0] && cpuSleep && (dmaReq || xferReq) |=> !gnt[0]);

  // R5
  xfer_mid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    gnt[1] && (xferPhase != '0) && !xferPhase[0] |=> gnt[1]);

  // R7
  dma_burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    gnt[2] && (dmaMode == 2'b11) && !dmaBurstDone |=> gnt[2]);

  // R10
  refresh_no_steal_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && gnt[2] && (dmaMode == 2'b11) && !dmaBurstDone |=> gnt[2]);

endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .xferReq      (xferReq),
  .dmaReq       (dmaReq),
  .cpuSplitBusy (cpuSplitBusy),
  .cpuSleep     (cpuSleep),
  .xferPhase    (xferPhase),
  .dmaMode      (dmaMode),
  .dmaBurstDone (dmaBurstDone),
  .refreshReq   (refreshReq),
  .gnt          (gnt)
);

// File: tb/prio_bus_arbiter_tb.sv
module prio_bus_arbiter_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       xferReq, dmaReq, cpuCycleEnd, cpuSplitBusy, cpuSleep;
  logic [2:0] xferPhase;
  logic [1:0] dmaMode;
  logic       dmaXferDone, dmaBlockDone, dmaBurstDone, refreshReq;
  logic [2:0] gnt;

  int checks = 0;
  int fails  = 0;
  int cur    = 0;   // expected owner: 0 CPU, 1 XFER, 2 DMA

  always #5 clk = ~clk;

  prio_bus_arbiter u_dut (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .dmaReq(dmaReq),
    .cpuCycleEnd(cpuCycleEnd), .cpuSplitBusy(cpuSplitBusy), .cpuSleep(cpuSleep),
    .xferPhase(xferPhase), .dmaMode(dmaMode), .dmaXferDone(dmaXferDone),
    .dmaBlockDone(dmaBlockDone), .dmaBurstDone(dmaBurstDone),
    .refreshReq(refreshReq), .gnt(gnt)
  );

  function automatic logic [2:0] oneHot(input int own);
    return 3'b001 << own;
  endfunction

  // Next owner from the release rules of the requirements
  function automatic int modelNext(input int own);
    bit atRelease;
    int win;
    case (own)
      0: atRelease = cpuSleep || (cpuCycleEnd && !cpuSplitBusy);
      1: atRelease = (xferPhase == 3'd0) || (xferPhase % 2 == 1);
      default: begin
        if (dmaMode == 2'b00 || dmaMode == 2'b01) atRelease = dmaXferDone;
        else if (dmaMode == 2'b10)                atRelease = dmaBlockDone;
        else                                      atRelease = dmaBurstDone;
      end
    endcase
    win = dmaReq ? 2 : (xferReq ? 1 : 0);
    return atRelease ? win : own;
  endfunction

  task automatic checkG(input logic [2:0] exp, input string tag);
    checks++;
    if (gnt !== exp) begin
      fails++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, gnt, exp);
    end
  endtask

  task automatic clearIns();
    xferReq = 0; dmaReq = 0; cpuCycleEnd = 0; cpuSplitBusy = 0; cpuSleep = 0;
    xferPhase = 0; dmaMode = 0; dmaXferDone = 0; dmaBlockDone = 0;
    dmaBurstDone = 0; refreshReq = 0;
  endtask

  // Directed step: inputs already set, expect owner after the edge
  task automatic stepExp(input int own, input string tag);
    @(posedge clk); @(negedge clk);
    checkG(oneHot(own), tag);
    cur = own;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd5028));
    clearIns();
    rstN = 0;
    repeat (3) @(negedge clk);
    checkG(3'b001, "R1 in reset");
    rstN = 1;
    @(negedge clk);
    checkG(3'b001, "R1 after reset");

    // R3: split access blocks, missing cycle end blocks, then hand over
    xferReq = 1; cpuSplitBusy = 1; cpuCycleEnd = 1;
    stepExp(0, "R3 split hold");
    cpuSplitBusy = 0; cpuCycleEnd = 0;
    stepExp(0, "R3 no cycle break");
    cpuCycleEnd = 1;
    stepExp(1, "R3 break handover");
    cpuCycleEnd = 0;

    // R5: mid-phase codes hold against a DMA request
    dmaReq = 1; xferPhase = 3'd2;
    stepExp(1, "R5 code2 hold");
    xferPhase = 3'd4;
    stepExp(1, "R5 code4 hold");
    xferPhase = 3'd6;
    stepExp(1, "R5 code6 hold");
    xferPhase = 3'd3;
    stepExp(2, "R5 R8 code3 release to dma");

    // R7 burst: other done strobes ignored; R11 dropped request holds
    dmaMode = 2'b11; dmaReq = 0; dmaXferDone = 1; dmaBlockDone = 1;
    stepExp(2, "R7 R11 burst hold");
    refreshReq = 1;
    stepExp(2, "R10 refresh no effect");
    dmaReq = 1; dmaBurstDone = 1;
    stepExp(2, "R9 owner keeps at release");
    dmaReq = 0;
    stepExp(1, "R7 burst done release");
    refreshReq = 0;

    // R7 block mode
    xferPhase = 3'd0; dmaReq = 1;
    stepExp(2, "R5 idle code release");
    dmaMode = 2'b10; dmaReq = 0; dmaXferDone = 1; dmaBurstDone = 1; dmaBlockDone = 0;
    stepExp(2, "R7 block hold");
    dmaBlockDone = 1;
    stepExp(1, "R7 block release");

    // R6 cycle steal and single modes
    dmaXferDone = 0; dmaBlockDone = 0; dmaBurstDone = 0;
    xferPhase = 3'd1; dmaReq = 1;
    stepExp(2, "R5 code1 release");
    dmaMode = 2'b00; dmaReq = 0; dmaBlockDone = 1; dmaBurstDone = 1;
    stepExp(2, "R6 steal hold");
    dmaXferDone = 1;
    stepExp(1, "R6 steal release");
    dmaXferDone = 0; dmaBlockDone = 0; dmaBurstDone = 0;
    xferPhase = 3'd5; dmaReq = 1; dmaMode = 2'b01;
    stepExp(2, "R5 code5 release");
    dmaReq = 0; dmaXferDone = 1;
    stepExp(1, "R6 single release");

    // R9 transfer controller keeps; R8 CPU default
    dmaXferDone = 0; xferPhase = 3'd7;
    stepExp(1, "R9 xfer keeps");
    xferReq = 0;
    stepExp(0, "R8 cpu default");

    // R4 sleep hands over inside a split access; R8 DMA wins
    cpuSleep = 1; cpuSplitBusy = 1; cpuCycleEnd = 0; xferReq = 1; dmaReq = 1;
    stepExp(2, "R4 R8 sleep handover");

    // Random phase checked against the model
    for (int i = 0; i < 3000; i++) begin
      int nxt;
      xferReq      = ($urandom % 3) == 0;
      dmaReq       = ($urandom % 4) == 0;
      cpuCycleEnd  = ($urandom % 2) == 0;
      cpuSplitBusy = ($urandom % 3) == 0;
      cpuSleep     = ($urandom % 8) == 0;
      xferPhase    = 3'($urandom % 8);
      dmaMode      = 2'($urandom % 4);
      dmaXferDone  = ($urandom % 4) == 0;
      dmaBlockDone = ($urandom % 5) == 0;
      dmaBurstDone = ($urandom % 6) == 0;
      refreshReq   = ($urandom % 2) == 0;
      nxt = modelNext(cur);
      stepExp(nxt, "R2 R8 random");
    end

    summary();
    $finish;
  end

endmodule